// File: doc/BRIEF.md
# Filtered Transmit Packet Counter Bank

This block holds a bank of 32-bit transmit packet counters. Each counter has its own filter word that picks the packets it counts. A packet matches on source (for example CPU-originated or forwarded). It can also match on output channel, queue index and ring/DSCP class. Each of those three fields can be replaced by a wildcard. On every transmitted-packet event, every enabled counter whose filter matches the event's attributes adds one.

Software sets up the filters and reads or loads the counters through a word-addressed register port. Reads are combinational and writes take one cycle. A typical setup gives each channel two counters: one filtering on the CPU source and one on the forwarded source, both with the queue and ring wildcards set.

Top module: `pkt_cnt_bank`

## Requirements
- R1: After reset every filter word and every counter value reads as zero.
- R2: A filter word stores bit 31 (enable), bit 30 (any channel), bit 29 (any queue), bit 28 (any ring), bits 27:24 (source), bits 20:16 (ring/DSCP class), bits 7:3 (channel) and bits 2:0 (queue). Bits 23:21 and 15:8 always read as zero.
- R3: Counter n has its filter word at word address 2n and its value at word address 2n+1, which is byte offsets 8n and 8n+4. Word addresses at or above 2*NUM_CNT read zero, and writes to them change nothing.
- R4: A counter whose enable bit is 0 never increments, whatever its other fields hold.
- R5: A counter only counts events whose 4-bit source equals its source field exactly. Source 0 is CPU transmit and 1 is forwarded transmit.
- R6: With bit 30 clear, the event channel must equal filter bits 7:3. With bit 30 set, the channel is not compared.
- R7: With bit 29 clear, the event queue must equal filter bits 2:0. With bit 29 set, the queue is not compared.
- R8: With bit 28 clear, the event ring/DSCP class must equal filter bits 20:16. With bit 28 set, the class is not compared.
- R9: A single event increments every counter that matches it by exactly one. Cycles with evt_valid_i low count nothing.
- R10: A write to a value address loads that value. A counter at 0xFFFFFFFF wraps to 0 on its next increment.
- R11: When a value write and a matching event hit the same counter in the same cycle, the written value is kept and the increment is lost.
- R12: An event sampled at a clock edge is visible on a read starting after that edge. A read made in the event's own cycle shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (6) | Word address for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| evt_valid_i | input | 1 | One transmitted packet this cycle |
| evt_src_i | input | 4 | Packet source code |
| evt_chan_i | input | 5 | Packet channel |
| evt_queue_i | input | 3 | Packet queue |
| evt_ring_i | input | 5 | Packet ring/DSCP class |

## Verification
The assertions assume that the event attributes are meaningful only while evt_valid_i is high. They also assume that the register port issues at most one write per cycle, to a word-aligned address. The bench drives all inputs one nanosecond after a rising edge, so every field is stable before the next edge. It also drives attribute values that would match while evt_valid_i is low, to show those cycles are ignored. The bench computes all reads from its own model of the filter rules. It does a write and an event in the same cycle only in the deliberate collision test.

// File: rtl/pkt_cnt_pkg.sv
package pkt_cnt_pkg;

  typedef struct packed {
    logic       en;
    logic       any_chan;
    logic       any_queue;
    logic       any_ring;
    logic [3:0] src;
    logic [4:0] ring;
    logic [4:0] chan;
    logic [2:0] queue;
  } cnt_cfg_t;

  typedef struct packed {
    logic [3:0] src;
    logic [4:0] ring;
    logic [4:0] chan;
    logic [2:0] queue;
  } pkt_evt_t;

  function automatic logic [31:0] cfg_to_word(cnt_cfg_t c);
    return {c.en, c.any_chan, c.any_queue, c.any_ring, c.src, 3'b000,
            c.ring, 8'h00, c.chan, c.queue};
  endfunction

  function automatic cnt_cfg_t word_to_cfg(logic [31:0] w);
    cnt_cfg_t c;
    c.en        = w[31];
    c.any_chan  = w[30];
    c.any_queue = w[29];
    c.any_ring  = w[28];
    c.src       = w[27:24];
    c.ring      = w[20:16];
    c.chan      = w[7:3];
    c.queue     = w[2:0];
    return c;
  endfunction

endpackage

// File: rtl/pkt_cnt_match.sv
module pkt_cnt_match
  import pkt_cnt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cnt_cfg_t cfg_i,
  input  logic     evt_valid_i,
  input  pkt_evt_t evt_i,
  output logic     hit_o
);

  logic src_ok, chan_ok, queue_ok, ring_ok;

  always_comb begin
    src_ok   = evt_i.src == cfg_i.src;
    chan_ok  = cfg_i.any_chan  || (evt_i.chan  == cfg_i.chan);
    queue_ok = cfg_i.any_queue || (evt_i.queue == cfg_i.queue);
    ring_ok  = cfg_i.any_ring  || (evt_i.ring  == cfg_i.ring);
    hit_o    = evt_valid_i && cfg_i.en && src_ok && chan_ok && queue_ok && ring_ok;
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |-> !hit_o); // R4
  AST_SRC_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> evt_i.src == cfg_i.src); // R5
  AST_CHAN_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !cfg_i.any_chan) |-> evt_i.chan == cfg_i.chan); // R6
  AST_QUEUE_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !cfg_i.any_queue) |-> evt_i.queue == cfg_i.queue); // R7
  AST_RING_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !cfg_i.any_ring) |-> evt_i.ring == cfg_i.ring); // R8
  AST_NO_IDLE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |-> !hit_o); // R9

endmodule

// File: rtl/pkt_cnt_cell.sv
module pkt_cnt_cell #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  // software load takes priority over a same-cycle increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (wr_i)  cnt_q <= wdata_i;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i)); // R11
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && inc_i) |=> cnt_q == $past(cnt_q) + 1'b1); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !inc_i) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/pkt_cnt_bank.sv
module pkt_cnt_bank
  import pkt_cnt_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int ADDR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              evt_valid_i,
  input  logic [3:0]        evt_src_i,
  input  logic [4:0]        evt_chan_i,
  input  logic [2:0]        evt_queue_i,
  input  logic [4:0]        evt_ring_i
);

  localparam int SLOT_W = ADDR_W - 1;
  localparam int CNT_W  = 32;

  logic [SLOT_W-1:0]  slot;
  logic               sel_val;
  logic               in_range;
  pkt_evt_t           evt;
  cnt_cfg_t           cfg_q   [NUM_CNT];
  logic [CNT_W-1:0]   cnt_w   [NUM_CNT];
  logic [NUM_CNT-1:0] hit_w;
  logic [NUM_CNT-1:0] cfg_wr;
  logic [NUM_CNT-1:0] val_wr;

  assign slot     = reg_addr_i[ADDR_W-1:1];
  assign sel_val  = reg_addr_i[0];
  assign in_range = {1'b0, slot} < ADDR_W'(NUM_CNT);

  assign evt.src   = evt_src_i;
  assign evt.chan  = evt_chan_i;
  assign evt.queue = evt_queue_i;
  assign evt.ring  = evt_ring_i;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    assign cfg_wr[g] = reg_we_i && !sel_val && (slot == SLOT_W'(g));
    assign val_wr[g] = reg_we_i &&  sel_val && (slot == SLOT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cfg_q[g] <= '0;
      else if (cfg_wr[g]) cfg_q[g] <= word_to_cfg(reg_wdata_i);
    end

    pkt_cnt_match u_match (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_i      (cfg_q[g]),
      .evt_valid_i(evt_valid_i),
      .evt_i      (evt),
      .hit_o      (hit_w[g])
    );

    pkt_cnt_cell #(.CNT_W(CNT_W)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (val_wr[g]),
      .wdata_i(reg_wdata_i),
      .inc_i  (hit_w[g]),
      .cnt_o  (cnt_w[g])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (slot == SLOT_W'(i))
        reg_rdata_o = sel_val ? cnt_w[i] : cfg_to_word(cfg_q[i]);
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_val |-> (reg_rdata_o[23:21] == 3'b000 && reg_rdata_o[15:8] == 8'h00)); // R2
  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range |-> reg_rdata_o == '0); // R3
  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cfg_wr, val_wr})); // R3

endmodule

// File: tb/pkt_cnt_bank_tb.sv
`timescale 1ns/1ps
module pkt_cnt_bank_tb;

  localparam int NC = 8;
  localparam logic [31:0] CFG_MASK = 32'hFF1F_00FF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        evt_valid_i = 1'b0;
  logic [3:0]  evt_src_i = '0;
  logic [4:0]  evt_chan_i = '0;
  logic [2:0]  evt_queue_i = '0;
  logic [4:0]  evt_ring_i = '0;

  always #2.5 clk = ~clk;

  pkt_cnt_bank #(.NUM_CNT(NC), .ADDR_W(6)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .evt_valid_i(evt_valid_i),
    .evt_src_i(evt_src_i), .evt_chan_i(evt_chan_i), .evt_queue_i(evt_queue_i),
    .evt_ring_i(evt_ring_i)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic rd_flag = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [5:0]  adr_q[$];
  logic [31:0] m_cfg [NC];
  logic [31:0] m_val [NC];

  function automatic bit m_hit(logic [31:0] c, logic [3:0] s, logic [4:0] ch,
                               logic [2:0] q, logic [4:0] r);
    return c[31] && (c[27:24] == s) && (c[30] || c[7:3] == ch) &&
           (c[29] || c[2:0] == q) && (c[28] || c[20:16] == r);
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] a);
    if (a[5:1] >= NC) return '0;
    return a[0] ? m_val[a[5:1]] : m_cfg[a[5:1]];
  endfunction

  task automatic m_apply(logic we, logic [5:0] a, logic [31:0] d, logic ev,
                         logic [3:0] s, logic [4:0] ch, logic [2:0] q, logic [4:0] r);
    for (int n = 0; n < NC; n++)
      if (ev && m_hit(m_cfg[n], s, ch, q, r)) m_val[n] = m_val[n] + 32'd1;
    if (we && a[5:1] < NC) begin
      if (a[0]) m_val[a[5:1]] = d;
      else      m_cfg[a[5:1]] = d & CFG_MASK;
    end
  endtask

  // one cycle: optional write, optional event, optional read of the same address
  task automatic cyc(logic we, logic [5:0] a, logic [31:0] d, logic ev, logic [3:0] s,
                     logic [4:0] ch, logic [2:0] q, logic [4:0] r, logic rd, string tag);
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = d;
    evt_valid_i = ev; evt_src_i = s; evt_chan_i = ch; evt_queue_i = q; evt_ring_i = r;
    if (rd) begin
      exp_q.push_back(m_read(a)); tag_q.push_back(tag); adr_q.push_back(a);
      rd_flag = 1'b1;
    end
    m_apply(we, a, d, ev, s, ch, q, r);
    @(posedge clk); #1;
    reg_we_i = 1'b0; evt_valid_i = 1'b0; rd_flag = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 4'd0, 5'd0, 3'd0, 5'd0, 1'b0, "");
  endtask

  task automatic rd(logic [5:0] a, string tag);
    cyc(1'b0, a, 32'd0, 1'b0, 4'd0, 5'd0, 3'd0, 5'd0, 1'b1, tag);
  endtask

  task automatic ev(logic [3:0] s, logic [4:0] ch, logic [2:0] q, logic [4:0] r);
    cyc(1'b0, 6'd0, 32'd0, 1'b1, s, ch, q, r, 1'b0, "");
  endtask

  // monitor: compare read data mid-cycle against the scoreboard
  always @(negedge clk) begin
    if (rd_flag && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      logic [5:0] a;
      e = exp_q.pop_front(); t = tag_q.pop_front(); a = adr_q.pop_front();
      total++;
      if (reg_rdata_o !== e) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", t, a, reg_rdata_o, e);
      end
    end
  end

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    for (int n = 0; n < NC; n++) begin m_cfg[n] = '0; m_val[n] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;

    for (int w = 0; w < 2 * NC; w++) rd(6'(w), "R1 reset");

    wr(6'd0, 32'hFFFF_FFFF);
    rd(6'd0, "R2 reserved bits");
    wr(6'd0, 32'h0000_0000);
    rd(6'd0, "R2 clear");

    // out-of-range address: write ignored, read zero
    wr(6'd20, 32'hDEAD_BEEF);
    wr(6'd21, 32'h1234_5678);
    rd(6'd20, "R3 oor cfg");
    rd(6'd21, "R3 oor val");
    for (int w = 0; w < 2 * NC; w++) rd(6'(w), "R3 no alias");

    wr(6'd0,  32'hB000_0018); // en, src0, chan3, any q, any ring
    wr(6'd2,  32'hB100_0018); // en, src1, chan3
    wr(6'd4,  32'hC009_0005); // en, any chan, src0, ring9, queue5
    wr(6'd6,  32'h7000_0000); // disabled, all wildcards
    wr(6'd8,  32'hF000_0000); // all wildcards, src0
    wr(6'd10, 32'hF200_0000); // all wildcards, src2
    wr(6'd12, 32'hF100_0000); // all wildcards, src1
    wr(6'd14, 32'h8F1F_00FF); // exact src15 chan31 ring31 queue7
    for (int n = 0; n < NC; n++) rd(6'(2 * n), "R3 cfg map");

    for (int k = 0; k < 40; k++)
      ev(4'(k % 4), 5'(k % 5 == 0 ? 3 : k % 7), 3'(k % 8), 5'((k * 3) % 32));
    ev(4'd0, 5'd7, 3'd5, 5'd9);
    ev(4'd0, 5'd3, 3'd5, 5'd8);
    ev(4'd0, 5'd3, 3'd4, 5'd9);
    ev(4'd15, 5'd31, 3'd7, 5'd31);
    ev(4'd15, 5'd31, 3'd6, 5'd31);
    ev(4'd15, 5'd30, 3'd7, 5'd31);
    ev(4'd15, 5'd31, 3'd7, 5'd30);
    ev(4'd14, 5'd31, 3'd7, 5'd31);
    // matching attributes but no valid strobe
    cyc(1'b0, 6'd0, 32'd0, 1'b0, 4'd0, 5'd3, 3'd5, 5'd9, 1'b0, "");
    cyc(1'b0, 6'd0, 32'd0, 1'b0, 4'd15, 5'd31, 3'd7, 5'd31, 1'b0, "");

    rd(6'd1,  "R6 chan filter");
    rd(6'd3,  "R5 src forwarded");
    rd(6'd5,  "R8 ring and R7 queue filter");
    rd(6'd7,  "R4 disabled");
    rd(6'd9,  "R9 all cpu");
    rd(6'd11, "R5 src2");
    rd(6'd13, "R9 all fwd");
    rd(6'd15, "R7 exact fields");

    wr(6'd9, 32'hFFFF_FFFF);
    rd(6'd9, "R10 load");
    ev(4'd0, 5'd1, 3'd1, 5'd1);
    rd(6'd9, "R10 wrap");
    wr(6'd9, 32'd12345);
    rd(6'd9, "R10 load value");

    cyc(1'b1, 6'd9, 32'h0000_0055, 1'b1, 4'd0, 5'd3, 3'd0, 5'd0, 1'b0, "");
    rd(6'd9, "R11 write wins");
    rd(6'd1, "R11 other counter still counts");

    cyc(1'b0, 6'd13, 32'd0, 1'b1, 4'd1, 5'd0, 3'd0, 5'd0, 1'b1, "R12 same cycle old");
    rd(6'd13, "R12 next cycle new");

    done = 1;
    report();
  end

endmodule